// File: doc/BRIEF.md
# Flash Block Erase and Verify Sequencer

This controller erases a single flash block and then proves the block is blank. It drives the flash control bits itself: write enable, erase setup, erase and erase verify. Each bit is switched in a fixed interlocked order, and every change is followed by its own programmed wait. After the erase pulse it walks the block from its first word address to its last. At each address it issues a dummy 0xFF write strobe, lets the array settle, and then reads one 16-bit word. A word is accepted only when every bit is 1. When a word fails, the erase pulse is repeated. This continues until the block verifies clean or a retry limit is reached. No pre-write of zeros is made before the erase.

A request names one block through a one-hot select vector, and it also gives that block's first and last word addresses. While the request runs, a watchdog enable output is raised, and a busy output stays high. The run ends with a one-cycle done pulse or a one-cycle fail pulse. Every wait is a parameter counted in clock cycles. To erase several blocks, the host issues one request per block, in turn.

The states and their transitions are as follows:
- IDLE goes to SWE_ON when a one-hot start arrives.
- SWE_ON (wait x) leads to ESU_ON (wait y), then ERASE (wait z), then ERS_OFF (wait alpha), then ESU_OFF (wait beta), then EV_ON (wait gamma).
- From EV_ON the verify walk runs DUMMY (one cycle), then SETTLE (wait epsilon), then READ (one cycle).
- From READ, a passing word that is not the last one returns to DUMMY, and a passing last word goes to EV_OFF_OK.
- A failing word in READ goes to EV_OFF_NG.
- EV_OFF_OK (wait eta) leads to SWE_OFF_OK (wait theta), then back to IDLE with done.
- EV_OFF_NG (wait eta) returns to ESU_ON if the retry limit has not been reached. Otherwise it goes to SWE_OFF_NG (wait theta), then to IDLE with fail.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the block is idle: busy, done, fail, all four control bits, the watchdog enable, the dummy strobe and the block-select output are 0.
- R2: A start in idle whose select vector does not have exactly one bit set raises fail for one cycle on the next clock. Busy stays 0 and no control bit changes.
- R3: The write enable rises first, and erase setup rises exactly X cycles later. The watchdog enable is high whenever erase setup is high.
- R4: Erase is high for exactly Z cycles per pulse and is raised exactly Y cycles after setup. Erase is only high while setup is high, and setup is only high while write enable is high.
- R5: After erase falls, setup falls exactly ALPHA cycles later and erase verify rises exactly BETA cycles after that. Verify and setup are never high together.
- R6: In every verify pass, one dummy strobe is given at each address in increasing order, starting from the first address. Each strobe is given while verify is high. A word counts as blank only if all 16 bits are 1.
- R7: After a clean pass, verify falls, write enable falls ETA cycles later, and done pulses THETA cycles after that. The watchdog enable is then 0. While busy, the block-select output equals the accepted one-hot vector.
- R8: A failing pass repeats the erase pulse. The retry count starts at 1 on each accepted start. If RETRY_MAX pulses have all failed verification, fail pulses THETA cycles after write enable falls.
- R9: Busy is high from the cycle after an accepted start until done or fail. Done and fail are single-cycle pulses and are never high together.
- R10: A start request while busy is ignored: the block selection and the result of the running erase are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to erase the selected block |
| blk_sel | input | BLK_W | One-hot block selection |
| blk_first | input | ADDR_W | First word address of the block |
| blk_last | input | ADDR_W | Last word address of the block |
| rd_word | input | 16 | Verify read data from the array |
| swe | output | 1 | Software write enable |
| esu | output | 1 | Erase setup |
| ers | output | 1 | Erase pulse |
| ev | output | 1 | Erase verify mode |
| blk_en | output | BLK_W | Block select driven to the array |
| vaddr | output | ADDR_W | Verify word address |
| dummy_wr | output | 1 | Dummy 0xFF write strobe |
| wdt_en | output | 1 | Watchdog enable |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure or rejection pulse |

## Verification
The assertions assume three things about the inputs:
- blk_first is not above blk_last.
- Both addresses are held steady until an accepted start has been sampled.
- Every wait parameter is at least 1.

The stimulus table keeps first at or below last in every row. A model of the array in the bench returns a word with one cleared bit at a chosen address for a chosen number of passes, and returns all ones otherwise. The bench drives inputs only half a cycle away from the sampling edge. A start with a different selection is injected in the middle of a run, and two non-one-hot selections are tried while idle.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SWE_ON,
        ST_ESU_ON,
        ST_ERASE,
        ST_ERS_OFF,
        ST_ESU_OFF,
        ST_EV_ON,
        ST_DUMMY,
        ST_SETTLE,
        ST_READ,
        ST_EV_OFF_OK,
        ST_EV_OFF_NG,
        ST_SWE_OFF_OK,
        ST_SWE_OFF_NG
    } fe_state_t;
endpackage

// File: rtl/fe_wait_timer.sv
module fe_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // the count of cycles already spent in the current state reaches limit-1
    assign expired = ({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end

    AST_TMR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !restart) |=> expired); // R4
endmodule

// File: rtl/fe_verify_addr.sv
module fe_verify_addr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr <= '0;
        else if (load)  addr <= base;
        else if (step)  addr <= addr + 1'b1;
    end

    assign at_last = (addr == last_addr);

    AST_NO_STEP_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !at_last); // R6
    AST_NO_LOAD_AND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step)); // R6
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int BLK_W     = 4,
    parameter int ADDR_W    = 8,
    parameter int CNT_W     = 16,
    parameter int RETRY_MAX = 6,
    parameter int T_X       = 8,
    parameter int T_Y       = 8,
    parameter int T_Z       = 2000,
    parameter int T_ALPHA   = 8,
    parameter int T_BETA    = 8,
    parameter int T_GAMMA   = 8,
    parameter int T_EPS     = 4,
    parameter int T_ETA     = 8,
    parameter int T_THETA   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  blk_sel,
    input  logic [ADDR_W-1:0] blk_first,
    input  logic [ADDR_W-1:0] blk_last,
    input  logic [15:0]       rd_word,
    output logic              swe,
    output logic              esu,
    output logic              ers,
    output logic              ev,
    output logic [BLK_W-1:0]  blk_en,
    output logic [ADDR_W-1:0] vaddr,
    output logic              dummy_wr,
    output logic              wdt_en,
    output logic              busy,
    output logic              done,
    output logic              fail
);
    localparam int RW = $clog2(RETRY_MAX + 1);
    localparam logic [RW-1:0]    RLIM = RW'(RETRY_MAX);
    localparam logic [CNT_W-1:0] LX = CNT_W'(T_X);
    localparam logic [CNT_W-1:0] LY = CNT_W'(T_Y);
    localparam logic [CNT_W-1:0] LZ = CNT_W'(T_Z);
    localparam logic [CNT_W-1:0] LA = CNT_W'(T_ALPHA);
    localparam logic [CNT_W-1:0] LB = CNT_W'(T_BETA);
    localparam logic [CNT_W-1:0] LG = CNT_W'(T_GAMMA);
    localparam logic [CNT_W-1:0] LE = CNT_W'(T_EPS);
    localparam logic [CNT_W-1:0] LH = CNT_W'(T_ETA);
    localparam logic [CNT_W-1:0] LT = CNT_W'(T_THETA);

    fe_state_t         state_q, state_n;
    logic [RW-1:0]     retry_q;
    logic [BLK_W-1:0]  sel_q;
    logic [ADDR_W-1:0] first_q, last_q;
    logic              done_q, fail_q;
    logic [CNT_W-1:0]  wait_lim;
    logic              tmr_exp, addr_last;
    logic              sel_ok, accept, word_ok;

    assign sel_ok  = ($countones(blk_sel) == 1);
    assign accept  = (state_q == ST_IDLE) && start && sel_ok;
    assign word_ok = &rd_word;

    // wait length for the current state
    always_comb begin
        unique case (state_q)
            ST_SWE_ON:                     wait_lim = LX;
            ST_ESU_ON:                     wait_lim = LY;
            ST_ERASE:                      wait_lim = LZ;
            ST_ERS_OFF:                    wait_lim = LA;
            ST_ESU_OFF:                    wait_lim = LB;
            ST_EV_ON:                      wait_lim = LG;
            ST_SETTLE:                     wait_lim = LE;
            ST_EV_OFF_OK, ST_EV_OFF_NG:    wait_lim = LH;
            ST_SWE_OFF_OK, ST_SWE_OFF_NG:  wait_lim = LT;
            default:                       wait_lim = CNT_W'(1);
        endcase
    end

    fe_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_n != state_q),
        .limit   (wait_lim),
        .expired (tmr_exp)
    );

    fe_verify_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == ST_EV_ON),
        .step      ((state_q == ST_READ) && word_ok && !addr_last),
        .base      (first_q),
        .last_addr (last_q),
        .addr      (vaddr),
        .at_last   (addr_last)
    );

    // next-state selection
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:       if (accept)  state_n = ST_SWE_ON;
            ST_SWE_ON:     if (tmr_exp) state_n = ST_ESU_ON;
            ST_ESU_ON:     if (tmr_exp) state_n = ST_ERASE;
            ST_ERASE:      if (tmr_exp) state_n = ST_ERS_OFF;
            ST_ERS_OFF:    if (tmr_exp) state_n = ST_ESU_OFF;
            ST_ESU_OFF:    if (tmr_exp) state_n = ST_EV_ON;
            ST_EV_ON:      if (tmr_exp) state_n = ST_DUMMY;
            ST_DUMMY:                   state_n = ST_SETTLE;
            ST_SETTLE:     if (tmr_exp) state_n = ST_READ;
            ST_READ: begin
                if (!word_ok)       state_n = ST_EV_OFF_NG;
                else if (addr_last) state_n = ST_EV_OFF_OK;
                else                state_n = ST_DUMMY;
            end
            ST_EV_OFF_OK:  if (tmr_exp) state_n = ST_SWE_OFF_OK;
            ST_EV_OFF_NG:  if (tmr_exp) state_n = (retry_q >= RLIM) ? ST_SWE_OFF_NG : ST_ESU_ON;
            ST_SWE_OFF_OK: if (tmr_exp) state_n = ST_IDLE;
            ST_SWE_OFF_NG: if (tmr_exp) state_n = ST_IDLE;
            default:                    state_n = ST_IDLE;
        endcase
    end

    // state register and per-request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            retry_q <= '0;
            sel_q   <= '0;
            first_q <= '0;
            last_q  <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            done_q  <= (state_q == ST_SWE_OFF_OK) && tmr_exp;
            fail_q  <= ((state_q == ST_SWE_OFF_NG) && tmr_exp) ||
                       ((state_q == ST_IDLE) && start && !sel_ok);
            if (accept) begin
                retry_q <= RW'(1);
                sel_q   <= blk_sel;
                first_q <= blk_first;
                last_q  <= blk_last;
            end else if ((state_q == ST_EV_OFF_NG) && tmr_exp && (retry_q < RLIM)) begin
                retry_q <= retry_q + 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        swe = 1'b0; esu = 1'b0; ers = 1'b0; ev = 1'b0;
        dummy_wr = 1'b0; wdt_en = 1'b1;
        unique case (state_q)
            ST_IDLE:                     wdt_en = 1'b0;
            ST_SWE_ON:     begin swe = 1'b1; wdt_en = 1'b0; end
            ST_ESU_ON:     begin swe = 1'b1; esu = 1'b1; end
            ST_ERASE:      begin swe = 1'b1; esu = 1'b1; ers = 1'b1; end
            ST_ERS_OFF:    begin swe = 1'b1; esu = 1'b1; end
            ST_ESU_OFF:          swe = 1'b1;
            ST_EV_ON, ST_SETTLE, ST_READ: begin swe = 1'b1; ev = 1'b1; end
            ST_DUMMY:      begin swe = 1'b1; ev = 1'b1; dummy_wr = 1'b1; end
            ST_EV_OFF_OK, ST_EV_OFF_NG:  swe = 1'b1;
            ST_SWE_OFF_OK, ST_SWE_OFF_NG: ;
            default:                     wdt_en = 1'b0;
        endcase
        busy   = (state_q != ST_IDLE);
        blk_en = busy ? sel_q : '0;
        done   = done_q;
        fail   = fail_q;
    end

    AST_ERS_IN_ESU:     assert property (@(posedge clk) disable iff (!rst_n) ers |-> esu); // R4
    AST_ESU_IN_SWE:     assert property (@(posedge clk) disable iff (!rst_n) esu |-> swe); // R4
    AST_EV_NOT_ESU:     assert property (@(posedge clk) disable iff (!rst_n) ev |-> !esu); // R5
    AST_WDT_COVERS_ESU: assert property (@(posedge clk) disable iff (!rst_n) esu |-> wdt_en); // R3
    AST_DUMMY_IN_EV:    assert property (@(posedge clk) disable iff (!rst_n) dummy_wr |-> ev); // R6
    AST_ONE_BLOCK:      assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(blk_en) == 1)); // R7
    AST_RETRY_BOUND:    assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (retry_q >= RW'(1) && retry_q <= RLIM)); // R8
    AST_RESULT_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(done && fail)); // R9
    AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_FAIL_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) fail |=> !fail); // R9
    AST_REJECT_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && ($countones(blk_sel) != 1)) |=> (fail && !busy && !swe)); // R2
    AST_SEL_HELD:       assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(blk_en)); // R10
endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
    localparam int TX = 3, TY = 2, TZ = 5, TA = 2, TB = 3, TG = 2, TE = 2, TH = 2, TT = 3;
    localparam int NMAX = 3;

    typedef struct packed {
        logic [3:0] sel;
        logic [7:0] a0;
        logic [7:0] a1;
        logic [7:0] bad;
        logic [3:0] fails;
        logic       ok;
        logic [3:0] pulses;
        logic [7:0] dummies;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{sel:4'b0001, a0:8'd4, a1:8'd7, bad:8'd5, fails:4'd0, ok:1'b1, pulses:4'd1, dummies:8'd4},
        '{sel:4'b0100, a0:8'd4, a1:8'd7, bad:8'd6, fails:4'd1, ok:1'b1, pulses:4'd2, dummies:8'd7},
        '{sel:4'b1000, a0:8'd2, a1:8'd2, bad:8'd2, fails:4'd2, ok:1'b1, pulses:4'd3, dummies:8'd3},
        '{sel:4'b0010, a0:8'd0, a1:8'd3, bad:8'd0, fails:4'd3, ok:1'b0, pulses:4'd3, dummies:8'd3},
        '{sel:4'b0001, a0:8'd8, a1:8'd9, bad:8'd9, fails:4'd5, ok:1'b0, pulses:4'd3, dummies:8'd6}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [3:0] blk_sel = '0;
    logic [7:0] blk_first = '0, blk_last = '0;
    logic [15:0] rd_word;
    logic swe, esu, ers, ev, dummy_wr, wdt_en, busy, done, fail;
    logic [3:0] blk_en;
    logic [7:0] vaddr;

    always #4 clk = ~clk;

    flash_erase_seq #(
        .BLK_W(4), .ADDR_W(8), .CNT_W(16), .RETRY_MAX(NMAX),
        .T_X(TX), .T_Y(TY), .T_Z(TZ), .T_ALPHA(TA), .T_BETA(TB),
        .T_GAMMA(TG), .T_EPS(TE), .T_ETA(TH), .T_THETA(TT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_sel(blk_sel),
        .blk_first(blk_first), .blk_last(blk_last), .rd_word(rd_word),
        .swe(swe), .esu(esu), .ers(ers), .ev(ev), .blk_en(blk_en), .vaddr(vaddr),
        .dummy_wr(dummy_wr), .wdt_en(wdt_en), .busy(busy), .done(done), .fail(fail)
    );

    int n_chk = 0, n_err = 0;
    // run context and monitor records
    logic [3:0] cur_sel;
    logic [7:0] cur_a0, cur_bad;
    int cur_fails;
    int cyc, n_pulses, n_dummy, ord_err, ebr_err, wdt_err, pulse_err;
    int t_swe_r, t_esu_r1, t_ers_r, t_ers_f, t_esu_f, t_ev_r, t_ev_f, t_swe_f, t_end;
    bit seen_done, seen_fail, esu_seen;
    logic [7:0] exp_addr;
    logic p_swe, p_esu, p_ers, p_ev, p_done, p_fail;

    // array model: a cleared bit at one address during the first failing passes
    assign rd_word = (n_pulses <= cur_fails && vaddr == cur_bad) ? 16'hFFEF : 16'hFFFF;

    task automatic clear_run();
        n_pulses = 0; n_dummy = 0; ord_err = 0; ebr_err = 0; wdt_err = 0; pulse_err = 0;
        seen_done = 0; seen_fail = 0; esu_seen = 0;
        t_swe_r = 0; t_esu_r1 = 0; t_ers_r = 0; t_ers_f = 0; t_esu_f = 0;
        t_ev_r = 0; t_ev_f = 0; t_swe_f = 0; t_end = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (swe && !p_swe) t_swe_r = cyc;
            if (!swe && p_swe) t_swe_f = cyc;
            if (esu && !p_esu && !esu_seen) begin t_esu_r1 = cyc; esu_seen = 1; end
            if (!esu && p_esu) t_esu_f = cyc;
            if (ers && !p_ers) begin t_ers_r = cyc; n_pulses++; end
            if (!ers && p_ers) t_ers_f = cyc;
            if (ev && !p_ev) begin t_ev_r = cyc; exp_addr = cur_a0; end
            if (!ev && p_ev) t_ev_f = cyc;
            if (dummy_wr) begin
                n_dummy++;
                if (!ev || vaddr != exp_addr) ord_err++;
                exp_addr = exp_addr + 8'd1;
            end
            if (busy && blk_en != cur_sel) ebr_err++;
            if (esu && !wdt_en) wdt_err++;
            if ((done && p_done) || (fail && p_fail) || (done && fail)) pulse_err++;
            if (done) begin seen_done = 1; t_end = cyc; end
            if (fail) begin seen_fail = 1; t_end = cyc; end
        end
        p_swe = swe; p_esu = esu; p_ers = ers; p_ev = ev; p_done = done; p_fail = fail;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    bit hung = 0;

    task automatic run_vec(input vec_t v, input bit inject);
        int wd;
        @(negedge clk); #1;
        clear_run();
        cur_sel = v.sel; cur_a0 = v.a0; cur_bad = v.bad; cur_fails = int'(v.fails);
        blk_sel = v.sel; blk_first = v.a0; blk_last = v.a1; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        chk("R9", "busy after accept", int'(busy), 1);
        wd = 0;
        while (!seen_done && !seen_fail && wd < 5000) begin
            if (inject && wd == 10) begin start = 1'b1; blk_sel = 4'b1000; end
            else begin start = 1'b0; blk_sel = v.sel; end
            @(negedge clk); #1;
            wd++;
        end
        start = 1'b0;
        if (wd >= 5000) begin
            hung = 1; n_chk++; n_err++;
            $display("FAIL R9 watchdog: actual=hung expected=finish");
            return;
        end
        chk(v.ok ? "R7" : "R8", "done seen", int'(seen_done), int'(v.ok));
        chk("R8", "fail seen", int'(seen_fail), int'(!v.ok));
        chk("R8", "erase pulses", n_pulses, int'(v.pulses));
        chk("R6", "dummy writes", n_dummy, int'(v.dummies));
        chk("R6", "address order errors", ord_err, 0);
        chk("R3", "swe to esu", t_esu_r1 - t_swe_r, TX);
        chk("R3", "esu without wdt", wdt_err, 0);
        chk("R4", "erase width", t_ers_f - t_ers_r, TZ);
        chk("R5", "ers fall to esu fall", t_esu_f - t_ers_f, TA);
        chk("R5", "esu fall to ev rise", t_ev_r - t_esu_f, TB);
        chk("R7", "ev fall to swe fall", t_swe_f - t_ev_f, TH);
        chk("R7", "swe fall to result", t_end - t_swe_f, TT);
        chk(inject ? "R10" : "R7", "block select while busy", ebr_err, 0);
        chk("R9", "pulse shape", pulse_err, 0);
        @(negedge clk); #1;
        chk("R9", "busy after result", int'(busy), 0);
        chk("R7", "wdt after result", int'(wdt_en), 0);
    endtask

    task automatic reject(input logic [3:0] s);
        @(negedge clk); #1;
        blk_sel = s; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        chk("R2", "reject fail pulse", int'(fail), 1);
        chk("R2", "reject busy", int'(busy), 0);
        chk("R2", "reject control bits", int'({swe, esu, ers, ev, wdt_en}), 0);
        @(negedge clk); #1;
        chk("R2", "reject pulse ends", int'(fail), 0);
    endtask

    initial begin
        cur_sel = '0; cur_a0 = '0; cur_bad = '0; cur_fails = 0; cyc = 0; exp_addr = '0;
        p_swe = 0; p_esu = 0; p_ers = 0; p_ev = 0; p_done = 0; p_fail = 0;
        clear_run();
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset outputs", int'({swe, esu, ers, ev, dummy_wr, wdt_en, busy, done, fail}), 0);
        chk("R1", "reset block select", int'(blk_en), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", "idle after reset", int'(busy), 0);
        for (int i = 0; i < 5; i++) begin
            if (!hung) run_vec(VECS[i], 1'b0);
        end
        if (!hung) reject(4'b0011);
        if (!hung) reject(4'b0000);
        if (!hung) run_vec(VECS[1], 1'b1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule